// File: doc/BRIEF.md
# Single-Channel Block Copy DMA with Self-Rearm

This block is one DMA channel that copies a block of 32-bit words from one memory region to another. Software sets up the channel by writing a small bank of 32-bit registers over a host port: two base addresses, a byte count and a direction bit. It then writes a go bit. The engine moves the block one word at a time over a request/ready memory port. Each word takes one read beat followed by one write beat.

When the last word has been written, the channel updates its own registers so that a follow-up block can be launched with no further setup. Both base addresses move forward by the number of bytes copied, and the byte count and go register return to zero. The enable bit takes the value of the top bit of the byte count, so software chooses per transfer whether the channel stays armed. A one-cycle interrupt marks the end of each transfer.

Only a software launch exists. The trigger-select register is storage and has no effect on the channel.

Top module: `blk_dma_chan`

Register map (byte offset on `host_addr`): 0x00 peripheral-side address, 0x04 system-side address, 0x08 byte count, 0x0C direction (bit 0), 0x10 trigger select (storage only), 0x14 enable (bit 0), 0x18 go, 0x1C status.

## Requirements
- R1: A write to offset 0x18 launches a transfer only when bit 0 of the written data is 1 and bit 0 of the enable register (0x14) is 1. Any other such write leaves the channel idle, causes no memory access, and the go register keeps reading 0.
- R2: The number of bytes moved is bits 30:0 of the byte count register, rounded down to a multiple of 4. Each word costs exactly one read beat and then one write beat.
- R3: With direction bit 0 equal to 0, words are read from consecutive system-side addresses and written to consecutive peripheral-side addresses. With direction bit 0 equal to 1, the peripheral side is the source and the system side is the destination.
- R4: The status register (0x1C) reads 0x10 while the channel is idle and 0x00 while a transfer is active. The go register reads 1 while a transfer is active.
- R5: At completion, the enable register takes the value of bit 31 of the byte count register.
- R6: At completion, both address registers grow by the rounded byte count, and the byte count register and go register read 0.
- R7: `irq` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the last write beat, or the one after an empty transfer finishes. The updated registers are visible in that cycle.
- R8: A transfer whose rounded byte count is 0 completes two cycles after the go write with no memory access.
- R9: While a transfer is active, host writes to offsets 0x00, 0x04, 0x08 and 0x18 have no effect.
- R10: If the host writes the enable register in the same cycle that the transfer completes, the value derived from bit 31 of the byte count wins.
- R11: After reset, every register reads 0 except status, which reads 0x10. `irq` and `mem_req` are low.
- R12: Once `mem_req` is raised, the request, its address, its direction and its write data stay unchanged until `mem_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 5 | Register byte offset, used for both reads and writes |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational from host_addr |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Data for a write beat |
| mem_rdata | input | 32 | Data returned for a read beat |
| mem_ready | input | 1 | Beat accepted at this clock edge |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Completion of a transfer and a host write to the enable register can land on the same clock edge. The bench provokes this by stalling the memory for several cycles and watching, away from the clock edge, for the cycle in which the final write beat is being accepted. It drives the enable write in exactly that cycle. It then judges the result by reading the enable register back in the interrupt cycle: bit 31 of the byte count must have taken precedence. A second overlap, a host write to an address or count register or a relaunch while the channel is busy, is judged by the final register values and by the count of memory beats and interrupts.

// File: rtl/blk_dma_pkg.sv
// Shared definitions for the block-copy DMA channel: register
// indices (the byte offset divided by 4) and engine states.
package blk_dma_pkg;
    localparam int REG_AW        = 5;
    localparam int STAT_IDLE_BIT = 4;

    typedef enum logic [2:0] {
        RG_PADDR = 3'd0,
        RG_SADDR = 3'd1,
        RG_LEN   = 3'd2,
        RG_DIR   = 3'd3,
        RG_TSEL  = 3'd4,
        RG_EN    = 3'd5,
        RG_GO    = 3'd6,
        RG_STAT  = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_EMPTY = 2'd3
    } eng_st_e;
endpackage

// File: rtl/blk_dma_regs.sv
// Register bank of the DMA channel.
// Holds the addresses, count, direction, trigger select and enable.
// Decides whether a go write launches a transfer, and applies the
// completion update. Assumes done is asserted only while busy is high.
module blk_dma_regs
    import blk_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_idx,
    input  logic [DW-1:0] wdata,
    input  logic [2:0]    rd_idx,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic          done,
    output logic          go,
    output logic [DW-1:0] src,
    output logic [DW-1:0] dst,
    output logic [DW-1:0] nbytes
);
    localparam int LW = 2;   // log2 of the word size in bytes

    logic [DW-1:0] paddr_q, saddr_q, len_q, tsel_q;
    logic          dir_q, en_q;
    logic          wr_paddr, wr_saddr, wr_len, wr_dir, wr_tsel, wr_en_r, wr_go;

    // Decode host writes per register.
    always_comb begin
        wr_paddr = wr_en && (wr_idx == RG_PADDR);
        wr_saddr = wr_en && (wr_idx == RG_SADDR);
        wr_len   = wr_en && (wr_idx == RG_LEN);
        wr_dir   = wr_en && (wr_idx == RG_DIR);
        wr_tsel  = wr_en && (wr_idx == RG_TSEL);
        wr_en_r  = wr_en && (wr_idx == RG_EN);
        wr_go    = wr_en && (wr_idx == RG_GO);
    end

    // Launch condition, and the operands handed to the engine.
    assign go     = wr_go && wdata[0] && en_q && !busy;
    assign nbytes = {1'b0, len_q[DW-2:LW], {LW{1'b0}}};
    assign src    = dir_q ? paddr_q : saddr_q;
    assign dst    = dir_q ? saddr_q : paddr_q;

    // Register updates: completion first, then host writes that are allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            saddr_q <= '0;
            len_q   <= '0;
            tsel_q  <= '0;
            dir_q   <= 1'b0;
            en_q    <= 1'b0;
        end else begin
            if (done) begin
                paddr_q <= paddr_q + nbytes;
                saddr_q <= saddr_q + nbytes;
                len_q   <= '0;
                en_q    <= len_q[DW-1];
            end else begin
                if (wr_paddr && !busy) paddr_q <= wdata;
                if (wr_saddr && !busy) saddr_q <= wdata;
                if (wr_len   && !busy) len_q   <= wdata;
                if (wr_en_r)           en_q    <= wdata[0];
            end
            if (wr_dir)  dir_q  <= wdata[0];
            if (wr_tsel) tsel_q <= wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (rd_idx)
            RG_PADDR: rdata = paddr_q;
            RG_SADDR: rdata = saddr_q;
            RG_LEN:   rdata = len_q;
            RG_DIR:   rdata[0] = dir_q;
            RG_TSEL:  rdata = tsel_q;
            RG_EN:    rdata[0] = en_q;
            RG_GO:    rdata[0] = busy;
            RG_STAT:  rdata[STAT_IDLE_BIT] = !busy;
            default:  rdata = '0;
        endcase
    end

    // R5 / R10: enable takes bit 31 of the count on completion.
    p_en_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (en_q == $past(len_q[DW-1])));

    // R9: the address and count registers are frozen while a transfer runs.
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(paddr_q) && $stable(saddr_q) && $stable(len_q)));
endmodule

// File: rtl/blk_dma_engine.sv
// Copy engine of the DMA channel.
// Captures source, destination and byte count at launch, then issues
// one read beat and one write beat per word over a request/ready port.
// Assumes nbytes is a multiple of the word size.
module blk_dma_engine
    import blk_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] nbytes,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);
    localparam logic [DW-1:0] WB = DW'(DW / 8);

    eng_st_e       state_q;
    logic [DW-1:0] src_q, dst_q, left_q, data_q;

    // Sequencer: launch, read beat, write beat, empty-transfer finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            left_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (go) begin
                    src_q   <= src;
                    dst_q   <= dst;
                    left_q  <= nbytes;
                    state_q <= (nbytes == '0) ? ST_EMPTY : ST_READ;
                end
                ST_READ: if (mem_ready) begin
                    data_q  <= mem_rdata;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: if (mem_ready) begin
                    src_q   <= src_q + WB;
                    dst_q   <= dst_q + WB;
                    left_q  <= left_q - WB;
                    state_q <= (left_q == WB) ? ST_IDLE : ST_READ;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive and completion strobe.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = mem_we ? dst_q : src_q;
        mem_wdata = data_q;
        done      = (state_q == ST_EMPTY) ||
                    ((state_q == ST_WRITE) && mem_ready && (left_q == WB));
    end

    // R1: an accepted launch makes the channel busy.
    p_go_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // R8: an idle channel makes no memory request.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R12: a stalled request holds its attributes.
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: rtl/blk_dma_chan.sv
// Top of the single-channel block-copy DMA.
// Joins the register bank and the copy engine, and registers the
// completion strobe into a one-cycle interrupt. Host reads are
// combinational from host_addr; the low two address bits are ignored.
module blk_dma_chan
    import blk_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ready,
    output logic              irq
);
    logic          busy, done, go;
    logic [DW-1:0] src, dst, nbytes;
    logic [2:0]    idx;

    assign idx = host_addr[REG_AW-1:2];

    blk_dma_regs #(.DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (host_wr),
        .wr_idx (idx),
        .wdata  (host_wdata),
        .rd_idx (idx),
        .rdata  (host_rdata),
        .busy   (busy),
        .done   (done),
        .go     (go),
        .src    (src),
        .dst    (dst),
        .nbytes (nbytes)
    );

    blk_dma_engine #(.DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .src       (src),
        .dst       (dst),
        .nbytes    (nbytes),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    // Interrupt pulse, one cycle after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= done;
    end

    // R7: the interrupt is a single-cycle pulse.
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: every completion raises the interrupt on the next cycle.
    p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq);
endmodule

// File: tb/blk_dma_chan_bench.sv
`timescale 1ns/1ps
module blk_dma_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    blk_dma_chan u_blk_dma_chan (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
    );

    // Memory model: 64 words, a programmable stall per beat.
    logic [31:0] mem [64];
    logic        init_req = 1'b0;
    logic [3:0]  stall = '0;
    logic [3:0]  wcnt = '0;
    int          acc_cnt = 0;
    int          irq_cnt = 0;
    int          viol = 0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;

    function automatic logic [31:0] pat(int i);
        return 32'h5A00_0000 | 32'(i * 257);
    endfunction

    assign mem_ready = mem_req && (wcnt >= stall);
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < 64; i++) mem[i] <= pat(i);
        end else if (mem_req && mem_ready && mem_we) begin
            mem[mem_addr[7:2]] <= mem_wdata;
        end
        if (!mem_req || mem_ready) wcnt <= '0;
        else                       wcnt <= wcnt + 4'd1;
        if (rst_n) begin
            if (mem_req && mem_ready) acc_cnt <= acc_cnt + 1;
            if (irq) irq_cnt <= irq_cnt + 1;
            if (prev_stall && (!mem_req || mem_addr != prev_addr)) viol <= viol + 1;
            prev_stall <= mem_req && !mem_ready;
            prev_addr  <= mem_addr;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rdchk(string tag, logic [4:0] a, logic [31:0] exp);
        host_addr = a;
        #0.1;
        chk(tag, host_rdata, exp);
    endtask

    task automatic fill_mem();
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
    endtask

    // Wait at negedges until irq is seen high (bounded).
    task automatic wait_irq(string tag);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (irq) return;
        end
        chk(tag, 32'd0, 32'd1);
    endtask

    typedef struct packed {
        logic [31:0] sys;
        logic [31:0] per;
        logic [31:0] len;
        logic        dir;
        logic [3:0]  stl;
    } vec_t;

    localparam vec_t VT [4] = '{
        '{32'h00, 32'h80, 32'h0000_0010, 1'b0, 4'd0},
        '{32'h20, 32'hC0, 32'h8000_000B, 1'b1, 4'd2},
        '{32'h40, 32'hA0, 32'h0000_0004, 1'b0, 4'd5},
        '{32'h10, 32'hF0, 32'h8000_0000, 1'b0, 4'd0}
    };

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int a0, i0, nw;
        logic [31:0] srcb, dstb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state.
        for (int r = 0; r < 7; r++) rdchk("R11 reg", 5'(r * 4), 32'h0);
        rdchk("R11 status", 5'h1C, 32'h10);
        chk("R11 irq", 32'(irq), 32'h0);
        chk("R11 mem_req", 32'(mem_req), 32'h0);

        // Table-driven transfers.
        for (int v = 0; v < 4; v++) begin
            fill_mem();
            stall = VT[v].stl;
            wr(5'h00, VT[v].per);
            wr(5'h04, VT[v].sys);
            wr(5'h08, VT[v].len);
            wr(5'h0C, {31'b0, VT[v].dir});
            wr(5'h14, 32'h1);
            a0 = acc_cnt; i0 = irq_cnt;
            wr(5'h18, 32'h1);
            wait_irq("R7 irq seen");
            nw = int'((VT[v].len & 32'h7FFF_FFFC) >> 2);
            chk((nw == 0) ? "R8 no access" : "R2 beat count", 32'(acc_cnt - a0), 32'(2 * nw));
            srcb = VT[v].dir ? VT[v].per : VT[v].sys;
            dstb = VT[v].dir ? VT[v].sys : VT[v].per;
            for (int k = 0; k < nw; k++)
                chk("R3 copied word", mem[int'(dstb >> 2) + k], pat(int'(srcb >> 2) + k));
            rdchk("R6 periph addr", 5'h00, VT[v].per + 32'(nw * 4));
            rdchk("R6 system addr", 5'h04, VT[v].sys + 32'(nw * 4));
            rdchk("R6 count cleared", 5'h08, 32'h0);
            rdchk("R6 go cleared", 5'h18, 32'h0);
            rdchk("R5 enable", 5'h14, {31'b0, VT[v].len[31]});
            rdchk("R4 status idle", 5'h1C, 32'h10);
            @(negedge clk);
            chk("R7 single pulse", 32'(irq), 32'h0);
            chk("R7 one irq", 32'(irq_cnt - i0), 32'h1);
        end

        // R1: go ignored when disabled, or when bit 0 of data is clear.
        wr(5'h08, 32'h10);
        wr(5'h14, 32'h0);
        a0 = acc_cnt; i0 = irq_cnt;
        wr(5'h18, 32'h1);
        repeat (10) @(negedge clk);
        chk("R1 disabled no access", 32'(acc_cnt - a0), 32'h0);
        rdchk("R1 disabled go", 5'h18, 32'h0);
        wr(5'h14, 32'h1);
        wr(5'h18, 32'h2);
        repeat (10) @(negedge clk);
        chk("R1 bit0 clear no access", 32'(acc_cnt - a0), 32'h0);
        chk("R1 no irq", 32'(irq_cnt - i0), 32'h0);
        rdchk("R1 status", 5'h1C, 32'h10);

        // R4 / R9: busy readback, writes ignored while active.
        fill_mem();
        stall = 4'd4;
        wr(5'h00, 32'h80);
        wr(5'h04, 32'h00);
        wr(5'h08, 32'h10);
        wr(5'h0C, 32'h0);
        wr(5'h14, 32'h1);
        a0 = acc_cnt; i0 = irq_cnt;
        wr(5'h18, 32'h1);
        rdchk("R4 go busy", 5'h18, 32'h1);
        rdchk("R4 status busy", 5'h1C, 32'h0);
        wr(5'h00, 32'hEC);
        wr(5'h04, 32'h3C);
        wr(5'h08, 32'h40);
        wr(5'h18, 32'h1);
        wait_irq("R9 irq seen");
        rdchk("R9 periph addr", 5'h00, 32'h90);
        rdchk("R9 system addr", 5'h04, 32'h10);
        rdchk("R9 count", 5'h08, 32'h0);
        repeat (30) @(negedge clk);
        chk("R9 beats", 32'(acc_cnt - a0), 32'h8);
        chk("R9 one irq", 32'(irq_cnt - i0), 32'h1);

        // R10: enable write in the completion cycle loses to count bit 31.
        stall = 4'd3;
        wr(5'h08, 32'h8000_0004);
        wr(5'h14, 32'h1);
        wr(5'h18, 32'h1);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (mem_req && mem_ready && mem_we) break;
        end
        host_wr = 1'b1; host_addr = 5'h14; host_wdata = 32'h0;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R10 irq in cycle", 32'(irq), 32'h1);
        rdchk("R10 enable kept", 5'h14, 32'h1);

        // R12: no stalled request changed.
        chk("R12 request stable", 32'(viol), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule